// File: doc/BRIEF.md
# Lowest-Priority Interrupt Redirection Router

This block steers each incoming interrupt request to exactly one of a set of CPUs. Every interrupt line owns a routing entry. The entry holds a one-hot target CPU and a flag that selects between two routing modes. In fixed mode the request always lands on the stored target. In redirectable mode the stored target acts only as the starting point of a search. The router then picks the CPU whose software-written priority hint is lowest. Ties go to the first CPU met when walking circularly upward from that starting point.

Software programs entries through a small write port that carries a line index, a CPU mask and a mode flag. Only the lowest set bit of the mask is kept. It sets per-CPU hints through a second write port. A combinational readback port returns the stored target and flag of any entry. A request presented on one clock edge produces a registered one-hot destination, together with a valid strobe and the line number, on the following cycle.

A build-time parameter states whether redirection is supported. When it is, every entry comes out of reset redirectable and aimed at CPU 0. When it is not, every entry is fixed, and the default targets are dealt out across the CPUs in round-robin order by line number.

Top module: `irr_router`

## Requirements
- R1: With redirection supported, after reset every entry reads back target CPU 0 (one-hot `0..01`) with the redirectable flag set, and every hint is minimal (00).
- R2: With redirection not supported, after reset entry i reads back target CPU (i mod NUM_CPUS) with the flag clear.
- R3: A write with a non-zero mask stores only its lowest-numbered set bit as the one-hot target, together with the flag, and readback returns exactly that.
- R4: A write with an all-zero mask is ignored: the entry's target and flag are unchanged.
- R5: A request on a fixed entry is delivered to its stored target whatever the hint values are.
- R6: A request on a redirectable entry is delivered to the CPU holding the numerically smallest hint.
- R7: Among CPUs tied at the smallest hint, the winner is the entry's default CPU if it is tied, otherwise the first tied CPU after it in circular ascending order.
- R8: A CPU whose hint is maximal (11) is never chosen unless every CPU is maximal, in which case the entry's default CPU is chosen.
- R9: Hints are encoded 00 minimal, 01 normal, 11 maximal; a hint write carrying 10, or naming a CPU index at or above NUM_CPUS, is ignored.
- R10: A request sampled on a clock edge raises `dest_valid` for exactly the next cycle, with `dest_sel` one-hot and `dest_line` equal to the requested line; with no request `dest_valid` stays low.
- R11: With redirection not supported, the flag is stored clear whatever value is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Routing entry write enable |
| cfg_line | input | LINE_W | Entry index to write |
| cfg_mask | input | NUM_CPUS | CPU mask; lowest set bit is kept |
| cfg_redir | input | 1 | Redirectable flag to store |
| hint_wr_en | input | 1 | Priority hint write enable |
| hint_cpu | input | CPU_W | CPU whose hint is written |
| hint_val | input | 2 | Hint level (00, 01, 11) |
| rd_line | input | LINE_W | Entry index to read back |
| rd_target | output | NUM_CPUS | Stored one-hot target of the read entry |
| rd_redir | output | 1 | Stored flag of the read entry |
| irq_valid | input | 1 | Interrupt request strobe |
| irq_line | input | LINE_W | Line raising the request |
| dest_valid | output | 1 | Destination valid, one cycle after the request |
| dest_sel | output | NUM_CPUS | One-hot chosen CPU |
| dest_line | output | LINE_W | Line the destination belongs to |

## Verification
A corrupted routing entry appears on the readback port in the cycle right after the write that caused it, and on the next request for that line one cycle after the request. A wrong hint register is visible only through redirectable requests. For that reason the directed cases set hint patterns in which each CPU in turn becomes the unique or the tied winner, so that a bad hint or a bad scan order changes `dest_sel` on the very next delivery. Errors in the output stage show as a misplaced or stretched `dest_valid`, or as a multi-hot `dest_sel`, in the cycle after the request.

// File: rtl/irr_pkg.sv
// Package: shared hint encoding for the interrupt redirection router.
// Assumes hints are two bits wide; code 2'b10 is reserved and never stored.
package irr_pkg;

    typedef enum logic [1:0] {
        HINT_IDLE    = 2'b00,
        HINT_BUSY    = 2'b01,
        HINT_OFFLINE = 2'b11
    } hint_e;

    localparam int HINT_W = 2;

    // True when a written hint code is one of the three defined levels.
    function automatic logic hint_is_legal(input logic [HINT_W-1:0] code);
        return (code == HINT_IDLE) || (code == HINT_BUSY) || (code == HINT_OFFLINE);
    endfunction

endpackage

// File: rtl/irr_route_table.sv
// Module: irr_route_table
// Holds one routing entry per interrupt line: a one-hot target CPU and a
// redirectable flag. Writes keep only the lowest set mask bit, and an empty
// mask leaves the entry untouched. Two combinational read ports are provided:
// one for software readback, one for the request lookup.
// Assumes NUM_CPUS >= 2 and NUM_LINES >= 1.
module irr_route_table #(
    parameter int NUM_CPUS        = 4,
    parameter int NUM_LINES       = 8,
    parameter bit REDIR_SUPPORTED = 1'b1,
    localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [LINE_W-1:0]   wr_line,
    input  logic [NUM_CPUS-1:0] wr_mask,
    input  logic                wr_redir,
    input  logic [LINE_W-1:0]   rd_line,
    output logic [NUM_CPUS-1:0] rd_target,
    output logic                rd_redir,
    input  logic [LINE_W-1:0]   lk_line,
    output logic [NUM_CPUS-1:0] lk_target,
    output logic                lk_redir
);

    logic [NUM_LINES-1:0][NUM_CPUS-1:0] tgt_q;
    logic [NUM_LINES-1:0]               redir_q;
    logic [NUM_CPUS-1:0]                wr_onehot;
    logic                               wr_flag;
    logic                               wr_accept;

    // Reset target of an entry: CPU 0, or round-robin when redirection is absent.
    function automatic logic [NUM_CPUS-1:0] reset_target(input int line);
        logic [NUM_CPUS-1:0] t;
        t = '0;
        if (REDIR_SUPPORTED) t[0] = 1'b1;
        else                 t[line % NUM_CPUS] = 1'b1;
        return t;
    endfunction

    // Isolate the lowest set mask bit and qualify the write.
    always_comb begin
        wr_onehot = wr_mask & (~wr_mask + NUM_CPUS'(1));
        wr_flag   = wr_redir & REDIR_SUPPORTED;
        wr_accept = wr_en && (|wr_mask) && (int'(wr_line) < NUM_LINES);
    end

    // Entry storage with per-line reset defaults.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < NUM_LINES; e++) begin
                tgt_q[e]   <= reset_target(e);
                redir_q[e] <= REDIR_SUPPORTED;
            end
        end else if (wr_accept) begin
            tgt_q[wr_line]   <= wr_onehot;
            redir_q[wr_line] <= wr_flag;
        end
    end

    // Software readback port; out-of-range lines read as zero.
    always_comb begin
        rd_target = '0;
        rd_redir  = 1'b0;
        if (int'(rd_line) < NUM_LINES) begin
            rd_target = tgt_q[rd_line];
            rd_redir  = redir_q[rd_line];
        end
    end

    // Request lookup port; out-of-range lines read as zero.
    always_comb begin
        lk_target = '0;
        lk_redir  = 1'b0;
        if (int'(lk_line) < NUM_LINES) begin
            lk_target = tgt_q[lk_line];
            lk_redir  = redir_q[lk_line];
        end
    end

endmodule

// File: rtl/irr_hint_bank.sv
// Module: irr_hint_bank
// One two-bit priority hint per CPU, written by software. Reserved codes and
// out-of-range CPU indices are dropped. All hints reset to the idle level.
// Assumes NUM_CPUS >= 2.
module irr_hint_bank
    import irr_pkg::*;
#(
    parameter int NUM_CPUS = 4,
    localparam int CPU_W = $clog2(NUM_CPUS)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [CPU_W-1:0]                 wr_cpu,
    input  logic [HINT_W-1:0]                wr_val,
    output logic [NUM_CPUS-1:0][HINT_W-1:0]  hints
);

    logic accept;

    // Qualify a hint write: legal code and an existing CPU.
    always_comb accept = wr_en && hint_is_legal(wr_val) && (int'(wr_cpu) < NUM_CPUS);

    // Hint registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NUM_CPUS; c++) hints[c] <= HINT_IDLE;
        end else if (accept) begin
            hints[wr_cpu] <= wr_val;
        end
    end

endmodule

// File: rtl/irr_lowest_pick.sv
// Module: irr_lowest_pick
// Combinational lowest-hint selection. It finds the smallest hint over all
// CPUs, then walks circularly from the default CPU and returns the first CPU
// holding that value, one-hot. When every CPU is at the maximal level the
// default itself matches first. Assumes `start` is one-hot.
module irr_lowest_pick
    import irr_pkg::*;
#(
    parameter int NUM_CPUS = 4,
    localparam int CPU_W = $clog2(NUM_CPUS)
) (
    input  logic [NUM_CPUS-1:0][HINT_W-1:0] hints,
    input  logic [NUM_CPUS-1:0]             start,
    output logic [NUM_CPUS-1:0]             pick
);

    logic [CPU_W-1:0]  start_idx;
    logic [HINT_W-1:0] min_val;
    logic              found;

    // Convert the one-hot default target into an index.
    always_comb begin
        start_idx = '0;
        for (int i = 0; i < NUM_CPUS; i++) begin
            if (start[i]) start_idx = CPU_W'(i);
        end
    end

    // Smallest hint value present across all CPUs.
    always_comb begin
        min_val = HINT_OFFLINE;
        for (int i = 0; i < NUM_CPUS; i++) begin
            if (hints[i] < min_val) min_val = hints[i];
        end
    end

    // Circular scan from the default CPU for the first minimal hint.
    always_comb begin
        pick  = '0;
        found = 1'b0;
        for (int k = 0; k < NUM_CPUS; k++) begin
            int c;
            c = int'(start_idx) + k;
            if (c >= NUM_CPUS) c = c - NUM_CPUS;
            if (!found && hints[c] == min_val) begin
                pick[c] = 1'b1;
                found   = 1'b1;
            end
        end
    end

endmodule

// File: rtl/irr_router.sv
// Module: irr_router (top)
// Interrupt redirection router. It looks up the routing entry of the
// requesting line and chooses either the stored fixed target or the
// lowest-hint CPU. The one-hot result, the valid strobe and the line number
// are registered, so they appear one cycle after the request is sampled.
// Assumes 2 <= NUM_CPUS <= 16; synchronous active-low reset.
module irr_router
    import irr_pkg::*;
#(
    parameter int NUM_CPUS        = 4,
    parameter int NUM_LINES       = 8,
    parameter bit REDIR_SUPPORTED = 1'b1,
    localparam int CPU_W  = $clog2(NUM_CPUS),
    localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr_en,
    input  logic [LINE_W-1:0]   cfg_line,
    input  logic [NUM_CPUS-1:0] cfg_mask,
    input  logic                cfg_redir,
    input  logic                hint_wr_en,
    input  logic [CPU_W-1:0]    hint_cpu,
    input  logic [1:0]          hint_val,
    input  logic [LINE_W-1:0]   rd_line,
    output logic [NUM_CPUS-1:0] rd_target,
    output logic                rd_redir,
    input  logic                irq_valid,
    input  logic [LINE_W-1:0]   irq_line,
    output logic                dest_valid,
    output logic [NUM_CPUS-1:0] dest_sel,
    output logic [LINE_W-1:0]   dest_line
);

    logic [NUM_CPUS-1:0][HINT_W-1:0] hints;
    logic [NUM_CPUS-1:0]             lk_target;
    logic                            lk_redir;
    logic [NUM_CPUS-1:0]             lowest;
    logic [NUM_CPUS-1:0]             chosen;

    irr_route_table #(
        .NUM_CPUS(NUM_CPUS),
        .NUM_LINES(NUM_LINES),
        .REDIR_SUPPORTED(REDIR_SUPPORTED)
    ) table_i (
        .clk(clk),
        .rst_n(rst_n),
        .wr_en(cfg_wr_en),
        .wr_line(cfg_line),
        .wr_mask(cfg_mask),
        .wr_redir(cfg_redir),
        .rd_line(rd_line),
        .rd_target(rd_target),
        .rd_redir(rd_redir),
        .lk_line(irq_line),
        .lk_target(lk_target),
        .lk_redir(lk_redir)
    );

    irr_hint_bank #(.NUM_CPUS(NUM_CPUS)) hints_i (
        .clk(clk),
        .rst_n(rst_n),
        .wr_en(hint_wr_en),
        .wr_cpu(hint_cpu),
        .wr_val(hint_val),
        .hints(hints)
    );

    irr_lowest_pick #(.NUM_CPUS(NUM_CPUS)) pick_i (
        .hints(hints),
        .start(lk_target),
        .pick(lowest)
    );

    // Choose between the fixed target and the lowest-hint CPU.
    always_comb chosen = lk_redir ? lowest : lk_target;

    // Register the destination one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dest_valid <= 1'b0;
            dest_sel   <= '0;
            dest_line  <= '0;
        end else begin
            dest_valid <= irq_valid;
            dest_sel   <= irq_valid ? chosen : '0;
            dest_line  <= irq_valid ? irq_line : '0;
        end
    end

endmodule

// File: rtl/irr_router_chk.sv
// Module: irr_router_chk
// Port-level property checker for irr_router, attached by bind below.
module irr_router_chk #(
    parameter int NUM_CPUS        = 4,
    parameter int NUM_LINES       = 8,
    parameter bit REDIR_SUPPORTED = 1'b1,
    localparam int CPU_W  = $clog2(NUM_CPUS),
    localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cfg_wr_en,
    input logic [LINE_W-1:0]   cfg_line,
    input logic [NUM_CPUS-1:0] cfg_mask,
    input logic [LINE_W-1:0]   rd_line,
    input logic [NUM_CPUS-1:0] rd_target,
    input logic                rd_redir,
    input logic                irq_valid,
    input logic [LINE_W-1:0]   irq_line,
    input logic                dest_valid,
    input logic [NUM_CPUS-1:0] dest_sel,
    input logic [LINE_W-1:0]   dest_line
);

    // R10: a request gives a valid one-hot destination for its line next cycle.
    assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |=> dest_valid && ($countones(dest_sel) == 1) && dest_line == $past(irq_line));

    // R10: no request, no valid strobe.
    assert_no_spurious_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_valid |=> !dest_valid);

    // R3: readback of an in-range entry is always one-hot.
    assert_rd_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rd_line) < NUM_LINES) |-> ($countones(rd_target) == 1));

    // R3: a non-zero write is read back as the lowest set mask bit.
    assert_lowest_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && (|cfg_mask) && cfg_line == rd_line && (int'(cfg_line) < NUM_LINES))
        |=> (rd_line != $past(rd_line)) ||
            (rd_target == ($past(cfg_mask) & ~($past(cfg_mask) - NUM_CPUS'(1)))));

    // R4: an all-zero mask write leaves the read entry unchanged.
    assert_zero_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && cfg_mask == '0 && cfg_line == rd_line)
        |=> (rd_line != $past(rd_line)) || $stable(rd_target));

    generate
        if (!REDIR_SUPPORTED) begin : g_fixed_only
            // R11: the flag never reads back set without redirection support.
            assert_flag_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
                !rd_redir);
        end
    endgenerate

endmodule

bind irr_router irr_router_chk #(
    .NUM_CPUS(NUM_CPUS),
    .NUM_LINES(NUM_LINES),
    .REDIR_SUPPORTED(REDIR_SUPPORTED)
) chk_i (
    .clk(clk),
    .rst_n(rst_n),
    .cfg_wr_en(cfg_wr_en),
    .cfg_line(cfg_line),
    .cfg_mask(cfg_mask),
    .rd_line(rd_line),
    .rd_target(rd_target),
    .rd_redir(rd_redir),
    .irq_valid(irq_valid),
    .irq_line(irq_line),
    .dest_valid(dest_valid),
    .dest_sel(dest_sel),
    .dest_line(dest_line)
);

// File: tb/irr_router_tb_top.sv
// Directed bench: one task per scenario, each checking its own results.
// dut_i supports redirection; dut_nr_i is the fixed-only variant on shared inputs.
module irr_router_tb_top;

    localparam int N  = 4;
    localparam int L  = 8;
    localparam int CW = 2;
    localparam int LW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr_en = 1'b0;
    logic [LW-1:0] cfg_line = '0;
    logic [N-1:0]  cfg_mask = '0;
    logic          cfg_redir = 1'b0;
    logic          hint_wr_en = 1'b0;
    logic [CW-1:0] hint_cpu = '0;
    logic [1:0]    hint_val = '0;
    logic [LW-1:0] rd_line = '0;
    logic          irq_valid = 1'b0;
    logic [LW-1:0] irq_line = '0;

    logic [N-1:0]  rd_target, nr_rd_target, dest_sel, nr_dest_sel;
    logic          rd_redir, nr_rd_redir, dest_valid, nr_dest_valid;
    logic [LW-1:0] dest_line, nr_dest_line;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    irr_router #(.NUM_CPUS(N), .NUM_LINES(L), .REDIR_SUPPORTED(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_line(cfg_line), .cfg_mask(cfg_mask), .cfg_redir(cfg_redir),
        .hint_wr_en(hint_wr_en), .hint_cpu(hint_cpu), .hint_val(hint_val),
        .rd_line(rd_line), .rd_target(rd_target), .rd_redir(rd_redir),
        .irq_valid(irq_valid), .irq_line(irq_line),
        .dest_valid(dest_valid), .dest_sel(dest_sel), .dest_line(dest_line)
    );

    irr_router #(.NUM_CPUS(N), .NUM_LINES(L), .REDIR_SUPPORTED(1'b0)) dut_nr_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_line(cfg_line), .cfg_mask(cfg_mask), .cfg_redir(cfg_redir),
        .hint_wr_en(hint_wr_en), .hint_cpu(hint_cpu), .hint_val(hint_val),
        .rd_line(rd_line), .rd_target(nr_rd_target), .rd_redir(nr_rd_redir),
        .irq_valid(irq_valid), .irq_line(irq_line),
        .dest_valid(nr_dest_valid), .dest_sel(nr_dest_sel), .dest_line(nr_dest_line)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic write_entry(input int line, input int mask, input bit redir);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_line = LW'(line); cfg_mask = N'(mask); cfg_redir = redir;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic write_hint(input int cpu, input int val);
        @(negedge clk);
        hint_wr_en = 1'b1; hint_cpu = CW'(cpu); hint_val = 2'(val);
        @(negedge clk);
        hint_wr_en = 1'b0;
    endtask

    // Request on dut_i and check the registered destination one cycle later.
    task automatic request(input int line, input int exp_sel, input string req);
        @(negedge clk);
        irq_valid = 1'b1; irq_line = LW'(line);
        @(negedge clk);
        irq_valid = 1'b0;
        check({req, " dest_valid"}, int'(dest_valid), 1);
        check({req, " dest_sel"}, int'(dest_sel), exp_sel);
        check({req, " dest_line"}, int'(dest_line), line);
        @(negedge clk);
        check({req, " valid drops"}, int'(dest_valid), 0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 idle valid", int'(dest_valid), 0);
        for (int i = 0; i < L; i++) begin
            rd_line = LW'(i);
            #1;
            check("R1 reset target", int'(rd_target), 1);
            check("R1 reset flag", int'(rd_redir), 1);
            check("R2 rr target", int'(nr_rd_target), 1 << (i % N));
            check("R2 rr flag", int'(nr_rd_redir), 0);
        end
        // R1: all hints idle, so the default CPU 0 wins.
        request(5, 4'b0001, "R1 idle hints");
    endtask

    task automatic t_fixed;
        write_entry(2, 4'b1100, 1'b0);
        rd_line = 3'd2; #1;
        check("R3 lowest bit", int'(rd_target), 4'b0100);
        check("R3 flag", int'(rd_redir), 0);
        write_entry(2, 0, 1'b1);
        rd_line = 3'd2; #1;
        check("R4 zero mask target", int'(rd_target), 4'b0100);
        check("R4 zero mask flag", int'(rd_redir), 0);
        write_hint(2, 2'b11);
        write_hint(0, 2'b01);
        request(2, 4'b0100, "R5 fixed ignores hints");
        write_hint(2, 2'b00);
        write_hint(0, 2'b00);
    endtask

    task automatic t_redirect;
        write_entry(3, 4'b0100, 1'b1);      // default CPU 2
        write_hint(0, 2'b01);
        write_hint(2, 2'b01);
        write_hint(3, 2'b01);
        request(3, 4'b0010, "R6 lowest hint");
        write_hint(1, 2'b01);
        request(3, 4'b0100, "R7 tie at default");
        write_hint(2, 2'b11);
        request(3, 4'b1000, "R7 next after default");
        write_hint(3, 2'b11);
        request(3, 4'b0001, "R7 circular wrap");
        write_hint(0, 2'b11);
        request(3, 4'b0010, "R8 skip maximal");
        write_hint(1, 2'b11);
        request(3, 4'b0100, "R8 all maximal default");
    endtask

    task automatic t_hint_codes;
        write_hint(1, 2'b10);               // reserved: ignored
        request(3, 4'b0100, "R9 reserved code");
        write_hint(1, 2'b00);
        request(3, 4'b0010, "R9 legal code");
    endtask

    task automatic t_flag_support;
        write_entry(1, 4'b1010, 1'b1);
        rd_line = 3'd1; #1;
        check("R11 supported flag", int'(rd_redir), 1);
        check("R11 fixed-only flag", int'(nr_rd_redir), 0);
        check("R3 fixed-only lowest bit", int'(nr_rd_target), 4'b0010);
    endtask

    initial begin
        t_reset();
        t_fixed();
        t_redirect();
        t_hint_codes();
        t_flag_support();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule